// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Checker

This block divides a serial bit stream by a fixed generator polynomial over GF(2), one bit per clock, using a single shift register. It has two modes, and both use the same datapath. In encode mode it takes a message and then shifts in as many zero bits as the generator's degree on its own. The register then holds the remainder, which the sender appends to the message in place of those zeros. In check mode it divides a whole received codeword, meaning the message followed by its remainder, and flags an error when anything other than zero is left over.

A frame begins with a one-cycle start strobe. The strobe loads a parameterized initial value into the register and latches the mode. Serial bits then arrive with a valid qualifier, and a last flag marks the final bit. A one-cycle done pulse marks the moment the result is ready. The generator's lower coefficients, the degree and the initial value are all parameters. The default generator is x^16+x^15+x^2+1. Setting the initial value to all ones gives the preset used with the 32-bit generator x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1.

Top module: `serial_crc`

## Requirements
- R1: After reset, busy, done and error are all 0.
- R2: The cycle after start is sampled high, remainder equals the INIT parameter and busy is 1. Start takes priority over any other input in that cycle.
- R3: Each shift moves the register one place towards its MSB and places the incoming bit in bit 0. When the bit leaving the MSB was 1, the result is XORed with POLY, which holds the generator coefficients below x^W.
- R4: While a frame is running, a cycle with bit_valid low leaves remainder unchanged.
- R5: In encode mode (check_mode sampled 0 at start), the engine shifts W zeros after the bit marked by bit_last. It then raises done for exactly one cycle. At that point remainder equals the remainder of (INIT, message, W zeros) divided by the generator. Example: generator 10011 with message 1011001 gives 1010.
- R6: During those W padding shifts, busy stays 1 and bit_valid, bit_in and bit_last are ignored.
- R7: In check mode (check_mode sampled 1 at start), done pulses in the cycle after the bit marked by bit_last is taken. A codeword made from an encoded message plus its remainder gives error 0. Example: 10110011010 with generator 10011.
- R8: error is 1 only while done is 1 in check mode, and only when remainder is nonzero.
- R9: With the 16-bit generator, every single-bit error, every double-bit error and every burst of 16 bits or fewer in a codeword raises error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads INIT and latches the mode; begins a frame |
| check_mode | input | 1 | Sampled with start: 0 to encode, 1 to check |
| bit_valid | input | 1 | bit_in carries a frame bit this cycle |
| bit_in | input | 1 | Serial data, first bit first |
| bit_last | input | 1 | Marks the final valid bit of the frame |
| busy | output | 1 | A frame or its padding is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| remainder | output | W | Current register contents; the remainder while done is high |
| error | output | 1 | Nonzero remainder at the end of a check |

## Verification
A behavioural long-division model, built on a queue of every bit shifted since the start, predicts remainder, done, busy and error on every clock. It is driven with short, all-zero, all-ones and random messages, and valid gaps and junk input during padding are mixed in. Gaps and junk expose any leak of ignored input into the register, and the frame-length variety exposes off-by-one padding counts. Clean codewords must pass. Single, double and short burst corruptions over the full codeword must all fail, which tells a true division apart from a register that merely shifts or XORs the wrong taps. A 4-bit instance reproduces the worked 10011 example exactly.

// File: rtl/serial_crc.sv
module serial_crc #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'h8005,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         check_mode,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         bit_last,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] remainder,
  output logic         error
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PAD} st_t;

  st_t           st;
  logic [W-1:0]  crc;
  logic          chk;
  logic [CW-1:0] cnt;

  wire          din = (st == S_RUN) ? bit_in : 1'b0;
  wire [W-1:0]  nxt = {crc[W-2:0], din} ^ (crc[W-1] ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      crc  <= INIT;
      chk  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st  <= S_RUN;
        crc <= INIT;
        chk <= check_mode;
        cnt <= '0;
      end else begin
        case (st)
          S_RUN: if (bit_valid) begin
            crc <= nxt;
            if (bit_last) begin
              if (chk) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st  <= S_PAD;
                cnt <= '0;
              end
            end
          end
          S_PAD: begin
            crc <= nxt;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(W - 1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign remainder = crc;
  assign error     = done & chk & (|crc);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (crc == INIT) && busy); // R2
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (st == S_RUN && !bit_valid && !start) |=> $stable(crc)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy) && !busy); // R5
  AST_PAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (st == S_PAD && !start) |=> busy || done); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(crc)); // R4
endmodule

// File: tb/test_serial_crc.sv
`timescale 1ns/1ps
module test_serial_crc;
  localparam logic [15:0] P16 = 16'h8005;
  localparam logic [15:0] I16 = 16'hFFFF;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic a_start = 0, a_mode = 0, a_valid = 0, a_bit = 0, a_last = 0;
  logic a_busy, a_done, a_err;
  logic [15:0] a_rem;
  logic b_start = 0, b_mode = 0, b_valid = 0, b_bit = 0, b_last = 0;
  logic b_busy, b_done, b_err;
  logic [3:0] b_rem;

  serial_crc #(.W(16), .POLY(P16), .INIT(I16)) i_serial_crc (
    .clk(clk), .rst_n(rst_n), .start(a_start), .check_mode(a_mode),
    .bit_valid(a_valid), .bit_in(a_bit), .bit_last(a_last),
    .busy(a_busy), .done(a_done), .remainder(a_rem), .error(a_err));

  serial_crc #(.W(4), .POLY(4'b0011), .INIT(4'b0000)) i_serial_crc_w4 (
    .clk(clk), .rst_n(rst_n), .start(b_start), .check_mode(b_mode),
    .bit_valid(b_valid), .bit_in(b_bit), .bit_last(b_last),
    .busy(b_busy), .done(b_done), .remainder(b_rem), .error(b_err));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] div_rem(input bit q[$], input int w, input logic [32:0] g);
    bit a[$];
    logic [31:0] r;
    int n;
    a = q;
    n = a.size();
    for (int i = 0; i + w < n; i++)
      if (a[i])
        for (int j = 0; j <= w; j++) a[i+j] = a[i+j] ^ g[w-j];
    r = '0;
    for (int k = 0; k < w; k++) r[w-1-k] = a[n-w+k];
    return r;
  endfunction

  // behavioural reference for the 16-bit instance
  localparam logic [32:0] G16 = {16'h0, 1'b1, P16};
  bit mq[$];
  int ph = 0, pad = 0;
  bit mchk = 0, xdone = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq = {};
      for (int k = 15; k >= 0; k--) mq.push_back(I16[k]);
      ph = 0; mchk = 0; xdone = 0;
    end else begin
      xdone = 0;
      if (a_start) begin
        mq = {};
        for (int k = 15; k >= 0; k--) mq.push_back(I16[k]);
        ph = 1; mchk = a_mode; pad = 0;
      end else if (ph == 1) begin
        if (a_valid) begin
          mq.push_back(a_bit);
          if (a_last) begin
            if (mchk) begin ph = 0; xdone = 1; end
            else begin ph = 2; pad = 0; end
          end
        end
      end else if (ph == 2) begin
        mq.push_back(1'b0);
        pad++;
        if (pad == 16) begin ph = 0; xdone = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [15:0] xr;
      xr = div_rem(mq, 16, G16)[15:0];
      check(a_rem == xr, "R3 remainder", a_rem, xr);
      check(a_done == xdone, "R5 done", a_done, xdone);
      check(a_busy == (ph != 0), "R6 busy", a_busy, ph != 0);
      check(a_err == (xdone && mchk && xr != 0), "R8 error", a_err, xdone && mchk && xr != 0);
    end
  end

  task automatic set_in(input bit sel, input bit s, input bit m, input bit v, input bit b, input bit l);
    if (sel) begin b_start = s; b_mode = m; b_valid = v; b_bit = b; b_last = l; end
    else begin a_start = s; a_mode = m; a_valid = v; a_bit = b; a_last = l; end
  endtask

  task automatic run_frame(input bit sel, input bit chk, input bit bits[$],
                           output logic [15:0] rem, output logic err);
    bit got;
    @(posedge clk); #2 set_in(sel, 1, chk, 0, 0, 0);
    @(posedge clk); #2 set_in(sel, 0, chk, 0, 0, 0);
    @(negedge clk);
    if (sel) check(b_rem == 4'b0000 && b_busy, "R2 load", {b_busy, b_rem}, 5'h10);
    else check(a_rem == I16 && a_busy, "R2 load", {a_busy, a_rem}, {1'b1, I16});
    foreach (bits[i]) begin
      if (i % 3 == 2) begin
        set_in(sel, 0, 0, 0, ~bits[i], 1);
        @(posedge clk); #2;
      end
      set_in(sel, 0, 0, 1, bits[i], i == bits.size() - 1);
      @(posedge clk); #2;
    end
    set_in(sel, 0, 0, 1, 1, 1);
    got = 0; rem = '0; err = 0;
    for (int k = 0; k < 24 && !got; k++) begin
      @(negedge clk);
      if (sel ? b_done : a_done) begin
        got = 1;
        rem = sel ? {12'h0, b_rem} : a_rem;
        err = sel ? b_err : a_err;
      end
    end
    set_in(sel, 0, 0, 0, 0, 0);
    check(got, "R5 done seen", got, 1);
  endtask

  task automatic enc_check(input bit msg[$]);
    logic [15:0] r;
    logic e;
    bit full[$], cw[$], bad[$];
    run_frame(0, 0, msg, r, e);
    full = {};
    for (int k = 15; k >= 0; k--) full.push_back(I16[k]);
    foreach (msg[i]) full.push_back(msg[i]);
    for (int k = 0; k < 16; k++) full.push_back(1'b0);
    check(r == div_rem(full, 16, G16)[15:0], "R5 encode remainder", r, div_rem(full, 16, G16));
    check(!e, "R8 no error in encode", e, 0);
    cw = msg;
    for (int k = 15; k >= 0; k--) cw.push_back(r[k]);
    run_frame(0, 1, cw, r, e);
    check(!e && r == 0, "R7 clean codeword", {e, r}, 0);
  endtask

  initial begin
    bit m[$], cw[$], bad[$];
    logic [15:0] r;
    logic e;
    logic [3:0] r4;
    logic [15:0] rw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!a_busy && !a_done && !a_err, "R1 reset", {a_busy, a_done, a_err}, 0);
    check(!b_busy && !b_done && !b_err, "R1 reset w4", {b_busy, b_done, b_err}, 0);
    @(posedge clk); #2 rst_n = 1;

    m = {1'b1}; enc_check(m);
    m = {}; for (int i = 0; i < 8; i++) m.push_back(0); enc_check(m);
    m = {}; for (int i = 0; i < 20; i++) m.push_back(1); enc_check(m);
    for (int t = 0; t < 4; t++) begin
      m = {}; for (int i = 0; i < 5 + 7 * t; i++) m.push_back(1'($urandom));
      enc_check(m);
    end

    // R9: error patterns on a 24-bit message codeword
    m = {}; for (int i = 0; i < 24; i++) m.push_back(1'($urandom));
    run_frame(0, 0, m, r, e);
    cw = m; for (int k = 15; k >= 0; k--) cw.push_back(r[k]);
    for (int i = 0; i < cw.size(); i++) begin
      bad = cw; bad[i] = ~bad[i];
      run_frame(0, 1, bad, r, e);
      check(e, "R9 single-bit error", e, 1);
    end
    for (int i = 0; i < cw.size(); i++)
      for (int j = i + 1; j < cw.size(); j++) begin
        bad = cw; bad[i] = ~bad[i]; bad[j] = ~bad[j];
        run_frame(0, 1, bad, r, e);
        check(e, "R9 double-bit error", e, 1);
      end
    for (int len = 3; len <= 16; len++)
      for (int p = 0; p + len <= cw.size(); p += 5) begin
        bad = cw;
        bad[p] = ~bad[p];
        bad[p+len-1] = ~bad[p+len-1];
        for (int k = p + 1; k < p + len - 1; k++) bad[k] = bad[k] ^ 1'($urandom);
        run_frame(0, 1, bad, r, e);
        check(e, "R9 burst error", e, 1);
      end

    // worked example on the 4-bit instance
    m = {1,0,1,1,0,0,1};
    run_frame(1, 0, m, rw, e);
    r4 = rw[3:0];
    check(r4 == 4'b1010, "R5 example remainder", r4, 4'b1010);
    cw = {1,0,1,1,0,0,1,1,0,1,0};
    run_frame(1, 1, cw, rw, e);
    check(!e && rw == 0, "R7 example codeword", {e, rw}, 0);
    cw[3] = ~cw[3];
    run_frame(1, 1, cw, rw, e);
    check(e, "R8 example corrupted", e, 1);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule